// File: doc/BRIEF.md
# Gated Sine Sample Sequencer

This block drives a converter's data path with a stepped sine wave instead of the normal sample data. A fixed 16-entry table of 12-bit offset-binary codes covers one full period. Each period starts at the 0-degree entry, code 0x800. A prescaler sets how long each table entry is held, so the sine frequency is the clock frequency divided by 32 × (presc + 1).

A gate input starts and stops the wave. When the gate falls, a mode bit picks one of two behaviours. In reset-on-gate mode the phase returns to 0 degrees and the channel-0 output is disabled, which models a high-impedance output. In freeze mode the sample being output is held, the output stays enabled, and the wave resumes from that sample when the gate rises again. In differential mode, channel 1 carries the bitwise complement of the channel-0 code.

A configuration check raises `cfg_bad` when the rest of the converter setup cannot support sine output. While `cfg_bad` is high the sequencer stays idle.

The control is a four-state machine:
- **IDLE**: not active. The phase and the prescaler are clear and both outputs are disabled.
- **RUN**: the gate is open and the table is being stepped.
- **PARK**: reset-on-gate mode with the gate closed. The phase is at 0 and channel 0 is disabled.
- **HOLD**: freeze mode with the gate closed. The phase and the prescaler are held and channel 0 stays enabled.

The next state does not depend on the current state. Every state moves as follows:
- Any state goes to IDLE when the sequencer is not active.
- Any state goes to RUN when the sequencer is active and the effective gate is high.
- Any state goes to PARK when the sequencer is active, the effective gate is low and `reset_on_gate` = 1.
- Any state goes to HOLD when the sequencer is active, the effective gate is low and `reset_on_gate` = 0.

The sequencer is active when `sine_en & ch0_en & !cfg_bad`. The effective gate is `gate0` in freeze mode. In reset-on-gate mode it is `gate0 & (gate1 | !diff_mode)`.

Top module: `sine_seq_top`

## Requirements
- R1: After reset, and in any cycle after `sine_en` or `ch0_en` was sampled low, `oe0` = `oe1` = 0 and `code0` = 0x800. The phase and the prescaler are cleared, so a later start outputs table entry 0 first.
- R2: The table entries for indices 0 to 15 are `round(2048 + 2047·sin(2π·k/16))`, which gives 0x800, 0xB0F, 0xDA7, 0xF63, 0xFFF, 0xF63, 0xDA7, 0xB0F, 0x800, 0x4F1, 0x259, 0x09D, 0x001, 0x09D, 0x259, 0x4F1. The index advances by 1 and wraps from 15 to 0.
- R3: While in RUN, each table entry stays on `code0` for exactly 2 × (`presc` + 1) cycles. The first entry appears in the cycle after the edge that samples the gate high.
- R4: With `reset_on_gate` = 1, one edge after the gate is sampled low, `oe0` = 0 and `code0` = 0x800. The next open gate restarts the wave at entry 0.
- R5: With `reset_on_gate` = 0, a low gate keeps `code0` at its current value and keeps `oe0` = 1. The prescaler count is kept too, so after the gate reopens the held entry completes its remaining hold time.
- R6: With `diff_mode` = 1, `code1` = 0xFFF − `code0` and `oe1` = `oe0`. With `diff_mode` = 0, `oe1` = 0 and `code1` = 0x800.
- R7: With `reset_on_gate` = 1 and `diff_mode` = 1, a low `gate1` acts like a low `gate0` and parks the sequencer. With `diff_mode` = 0, `gate1` has no effect.
- R8: `cfg_bad` is combinational and is 1 when `sine_en` = 1 and any of the following holds:
  - `continuous_mode` = 0;
  - `settle0` ≠ 0;
  - `trig0` ≠ 2'b10, the gate-triggered code;
  - `diff_mode` = 1 and `settle1` ≠ 0;
  - `diff_mode` = 1 and `trig1` ≠ 2'b10.

  One edge after `cfg_bad` is sampled high, `oe0` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sine_en | input | 1 | Sine generation enable |
| ch0_en | input | 1 | Channel 0 enable |
| reset_on_gate | input | 1 | 1: a low gate parks at phase 0 with the output off; 0: a low gate freezes the wave |
| diff_mode | input | 1 | Differential output on channel 1 |
| continuous_mode | input | 1 | Converter is in continuous conversion |
| settle0 | input | SETTLE_W | Channel 0 settle time |
| settle1 | input | SETTLE_W | Channel 1 settle time |
| trig0 | input | 2 | Channel 0 trigger mode (2'b10 = gate triggered) |
| trig1 | input | 2 | Channel 1 trigger mode (2'b10 = gate triggered) |
| presc | input | PRESC_W | Prescaler; each entry is held for 2 × (presc + 1) cycles |
| gate0 | input | 1 | Channel 0 gate |
| gate1 | input | 1 | Channel 1 gate |
| code0 | output | 12 | Channel 0 code |
| code1 | output | 12 | Channel 1 code |
| oe0 | output | 1 | Channel 0 output enable |
| oe1 | output | 1 | Channel 1 output enable |
| cfg_bad | output | 1 | Configuration does not support sine output |

## Verification
The hardest case to reach is a freeze in the middle of a hold interval followed by a resume. The held entry must then finish only its remaining cycles, which shows that the prescaler count was kept and not restarted. The bench reaches this case by closing the gate in freeze mode after a number of cycles that is not a multiple of the hold length. During the pause, its reference model counts only the edges on which the gate was open. Parking through a low `gate1` is reached by enabling differential mode in reset-on-gate mode and closing only `gate1` while `gate0` stays high.

// File: rtl/sine_seq_pkg.sv
package sine_seq_pkg;
    localparam int CODE_W  = 12;
    localparam int PHASE_W = 4;
    localparam logic [1:0] TRIG_GATE = 2'b10;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [PHASE_W-1:0] phase_t;

    localparam code_t CODE_MID = code_t'(12'h800);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PARK,
        ST_HOLD
    } seq_state_t;
endpackage

// File: rtl/sine_cfg_check.sv
module sine_cfg_check #(
    parameter int SETTLE_W = 8
) (
    input  logic                sine_en,
    input  logic                diff_mode,
    input  logic                continuous_mode,
    input  logic [SETTLE_W-1:0] settle0,
    input  logic [SETTLE_W-1:0] settle1,
    input  logic [1:0]          trig0,
    input  logic [1:0]          trig1,
    output logic                cfg_bad
);
    import sine_seq_pkg::*;

    logic ch0_wrong;
    logic ch1_wrong;

    always_comb begin
        ch0_wrong = (settle0 != '0) || (trig0 != TRIG_GATE);
        ch1_wrong = diff_mode && ((settle1 != '0) || (trig1 != TRIG_GATE));
        cfg_bad   = sine_en && (!continuous_mode || ch0_wrong || ch1_wrong);
    end

    always_comb begin
        a_r8_disabled_clean: assert (sine_en || !cfg_bad)
            else $error("R8: cfg_bad set while sine generation is off");
    end
endmodule

// File: rtl/sine_presc.sv
module sine_presc #(
    parameter int PRESC_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int CNT_W = PRESC_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             at_term;

    always_comb begin
        term    = {presc, 1'b1};
        at_term = (cnt >= term);
        tick    = step && at_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            if (at_term) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    a_r3_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0))
        else $error("R3: count did not wrap after a tick");

    a_r5_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(cnt))
        else $error("R5: count moved while not stepping");
endmodule

// File: rtl/sine_rom.sv
module sine_rom (
    input  sine_seq_pkg::phase_t idx,
    output sine_seq_pkg::code_t  code
);
    always_comb begin
        unique case (idx)
            4'd0:  code = 12'h800;
            4'd1:  code = 12'hB0F;
            4'd2:  code = 12'hDA7;
            4'd3:  code = 12'hF63;
            4'd4:  code = 12'hFFF;
            4'd5:  code = 12'hF63;
            4'd6:  code = 12'hDA7;
            4'd7:  code = 12'hB0F;
            4'd8:  code = 12'h800;
            4'd9:  code = 12'h4F1;
            4'd10: code = 12'h259;
            4'd11: code = 12'h09D;
            4'd12: code = 12'h001;
            4'd13: code = 12'h09D;
            4'd14: code = 12'h259;
            4'd15: code = 12'h4F1;
            default: code = 12'h800;
        endcase
    end
endmodule

// File: rtl/sine_fsm.sv
module sine_fsm (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            active,
    input  logic                            gate0,
    input  logic                            gate1,
    input  logic                            reset_on_gate,
    input  logic                            diff_mode,
    input  logic                            tick,
    output sine_seq_pkg::seq_state_t        state,
    output sine_seq_pkg::phase_t            phase,
    output logic                            clear,
    output logic                            step
);
    import sine_seq_pkg::*;

    seq_state_t nxt;
    logic       gate_ok;
    seq_state_t closed_tgt;

    always_comb begin
        if (reset_on_gate) begin
            gate_ok    = gate0 && (gate1 || !diff_mode);
            closed_tgt = ST_PARK;
        end else begin
            gate_ok    = gate0;
            closed_tgt = ST_HOLD;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!active)      nxt = ST_IDLE;
                else if (gate_ok) nxt = ST_RUN;
                else              nxt = closed_tgt;
            end
            ST_RUN: begin
                if (!active)      nxt = ST_IDLE;
                else if (gate_ok) nxt = ST_RUN;
                else              nxt = closed_tgt;
            end
            ST_PARK: begin
                if (!active)      nxt = ST_IDLE;
                else if (gate_ok) nxt = ST_RUN;
                else              nxt = closed_tgt;
            end
            ST_HOLD: begin
                if (!active)      nxt = ST_IDLE;
                else if (gate_ok) nxt = ST_RUN;
                else              nxt = closed_tgt;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        clear = (nxt == ST_IDLE) || (nxt == ST_PARK);
        step  = (state == ST_RUN) && (nxt == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (tick) begin
            phase <= phase + PHASE_W'(1);
        end
    end

    a_r1_idle_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (phase == '0))
        else $error("R1: idle with nonzero phase");

    a_r4_park_on_low_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_on_gate && active && !gate0) |=> ((state == ST_PARK) && (phase == '0)))
        else $error("R4: low gate did not park at phase 0");

    a_r5_freeze_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_on_gate && active && !gate0) |=> $stable(phase))
        else $error("R5: phase moved while frozen");

    a_r7_gate1_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_on_gate && diff_mode && active && !gate1) |=> (state == ST_PARK))
        else $error("R7: low gate1 did not park");

    a_r2_phase_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> ((phase == $past(phase)) ||
                               (phase == $past(phase) + PHASE_W'(1)) ||
                               (phase == '0)))
        else $error("R2: phase skipped an entry");
endmodule

// File: rtl/sine_out.sv
module sine_out (
    input  sine_seq_pkg::seq_state_t state,
    input  sine_seq_pkg::code_t      rom_code,
    input  logic                     diff_mode,
    output sine_seq_pkg::code_t      code0,
    output sine_seq_pkg::code_t      code1,
    output logic                     oe0,
    output logic                     oe1
);
    import sine_seq_pkg::*;

    always_comb begin
        unique case (state)
            ST_RUN, ST_HOLD: begin
                code0 = rom_code;
                oe0   = 1'b1;
            end
            ST_IDLE, ST_PARK: begin
                code0 = CODE_MID;
                oe0   = 1'b0;
            end
            default: begin
                code0 = CODE_MID;
                oe0   = 1'b0;
            end
        endcase
        if (diff_mode) begin
            code1 = ~code0;
            oe1   = oe0;
        end else begin
            code1 = CODE_MID;
            oe1   = 1'b0;
        end
    end

    always_comb begin
        a_r6_pair_sum: assert (!oe1 || (({1'b0, code0} + {1'b0, code1}) == 13'h0FFF))
            else $error("R6: channel 1 is not the complement");
        a_r1_off_is_mid: assert (oe0 || (code0 == CODE_MID))
            else $error("R1: disabled channel 0 not at midscale");
    end
endmodule

// File: rtl/sine_seq_top.sv
module sine_seq_top #(
    parameter int PRESC_W  = 7,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sine_en,
    input  logic                ch0_en,
    input  logic                reset_on_gate,
    input  logic                diff_mode,
    input  logic                continuous_mode,
    input  logic [SETTLE_W-1:0] settle0,
    input  logic [SETTLE_W-1:0] settle1,
    input  logic [1:0]          trig0,
    input  logic [1:0]          trig1,
    input  logic [PRESC_W-1:0]  presc,
    input  logic                gate0,
    input  logic                gate1,
    output logic [11:0]         code0,
    output logic [11:0]         code1,
    output logic                oe0,
    output logic                oe1,
    output logic                cfg_bad
);
    import sine_seq_pkg::*;

    seq_state_t state;
    phase_t     phase;
    code_t      rom_code;
    logic       active;
    logic       clear;
    logic       step;
    logic       tick;

    assign active = sine_en && ch0_en && !cfg_bad;

    sine_cfg_check #(.SETTLE_W(SETTLE_W)) u_cfg (
        .sine_en         (sine_en),
        .diff_mode       (diff_mode),
        .continuous_mode (continuous_mode),
        .settle0         (settle0),
        .settle1         (settle1),
        .trig0           (trig0),
        .trig1           (trig1),
        .cfg_bad         (cfg_bad)
    );

    sine_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .gate0         (gate0),
        .gate1         (gate1),
        .reset_on_gate (reset_on_gate),
        .diff_mode     (diff_mode),
        .tick          (tick),
        .state         (state),
        .phase         (phase),
        .clear         (clear),
        .step          (step)
    );

    sine_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (step),
        .presc (presc),
        .tick  (tick)
    );

    sine_rom u_rom (
        .idx  (phase),
        .code (rom_code)
    );

    sine_out u_out (
        .state     (state),
        .rom_code  (rom_code),
        .diff_mode (diff_mode),
        .code0     (code0),
        .code1     (code1),
        .oe0       (oe0),
        .oe1       (oe1)
    );

    a_r8_bad_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> !oe0)
        else $error("R8: output enabled after bad configuration");

    a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sine_en || !ch0_en) |=> (!oe0 && !oe1))
        else $error("R1: outputs enabled while disabled");
endmodule

// File: tb/sine_seq_top_tb.sv
`timescale 1ns/1ps
module sine_seq_top_tb;
    localparam int PRESC_W  = 7;
    localparam int SETTLE_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sine_en = 1'b1;
    logic                ch0_en = 1'b1;
    logic                reset_on_gate = 1'b1;
    logic                diff_mode = 1'b0;
    logic                continuous_mode = 1'b1;
    logic [SETTLE_W-1:0] settle0 = '0;
    logic [SETTLE_W-1:0] settle1 = '0;
    logic [1:0]          trig0 = 2'b10;
    logic [1:0]          trig1 = 2'b10;
    logic [PRESC_W-1:0]  presc = '0;
    logic                gate0 = 1'b0;
    logic                gate1 = 1'b0;
    logic [11:0]         code0;
    logic [11:0]         code1;
    logic                oe0;
    logic                oe1;
    logic                cfg_bad;

    int nvec = 0;
    int nbad = 0;
    int mj   = 0;
    int cyc  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sine_seq_top #(.PRESC_W(PRESC_W), .SETTLE_W(SETTLE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sine_en(sine_en), .ch0_en(ch0_en),
        .reset_on_gate(reset_on_gate), .diff_mode(diff_mode),
        .continuous_mode(continuous_mode), .settle0(settle0), .settle1(settle1),
        .trig0(trig0), .trig1(trig1), .presc(presc), .gate0(gate0), .gate1(gate1),
        .code0(code0), .code1(code1), .oe0(oe0), .oe1(oe1), .cfg_bad(cfg_bad)
    );

    function automatic logic [11:0] ref_code(int k);
        real v;
        v = 2048.0 + 2047.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 16.0);
        return 12'($rtoi(v + 0.5));
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic check_off(string req);
        check(req, {11'd0, oe0}, 12'd0);
        check(req, code0, 12'h800);
    endtask

    // one check per cycle; mj counts the edges on which the wave stepped
    task automatic run_check(string req, int n, int hold);
        for (int i = 0; i < n; i++) begin
            logic [11:0] e;
            e = ref_code((mj / hold) % 16);
            check(req, code0, e);
            check(req, {11'd0, oe0}, 12'd1);
            if (diff_mode) begin
                check({req, " R6"}, code1, 12'hFFF - e);
                check({req, " R6"}, {11'd0, oe1}, 12'd1);
            end else begin
                check({req, " R6"}, code1, 12'h800);
                check({req, " R6"}, {11'd0, oe1}, 12'd0);
            end
            @(negedge clk);
            mj++;
        end
    endtask

    task automatic start_gate();
        gate0 = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check_off("R1 reset");
        check("R1 reset oe1", {11'd0, oe1}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_off("R1 after reset");
    endtask

    task automatic t_wave();
        reset_on_gate = 1'b1;
        presc = 7'd0;
        mj = 0;
        start_gate();
        run_check("R2 R3 presc0", 40, 2);
        gate0 = 1'b0;
        @(negedge clk);
        check_off("R4 park");
        presc = 7'd2;
        mj = 0;
        start_gate();
        run_check("R3 presc2", 100, 6);
        gate0 = 1'b0;
        @(negedge clk);
        check_off("R4 park again");
    endtask

    task automatic t_freeze();
        logic [11:0] e;
        reset_on_gate = 1'b0;
        presc = 7'd1;
        mj = 0;
        start_gate();
        run_check("R5 before pause", 11, 4);
        gate0 = 1'b0;
        e = ref_code((mj / 4) % 16);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R5 held code", code0, e);
            check("R5 held oe0", {11'd0, oe0}, 12'd1);
        end
        start_gate();
        run_check("R5 resume", 30, 4);
        gate0 = 1'b0;
        @(negedge clk);
        reset_on_gate = 1'b1;
        @(negedge clk);
        check_off("R4 mode switch parks");
    endtask

    task automatic t_diff();
        diff_mode = 1'b1;
        reset_on_gate = 1'b1;
        presc = 7'd0;
        gate1 = 1'b1;
        mj = 0;
        start_gate();
        run_check("R6 diff", 20, 2);
        gate1 = 1'b0;
        @(negedge clk);
        check_off("R7 gate1 parks");
        check("R7 oe1 off", {11'd0, oe1}, 12'd0);
        gate1 = 1'b1;
        mj = 0;
        @(negedge clk);
        run_check("R7 restart at entry 0", 10, 2);
        gate0 = 1'b0;
        gate1 = 1'b0;
        diff_mode = 1'b0;
        @(negedge clk);
        mj = 0;
        start_gate();
        run_check("R7 gate1 ignored single-ended", 10, 2);
    endtask

    task automatic t_cfg();
        trig0 = 2'b01;
        #1 check("R8 trig0", {11'd0, cfg_bad}, 12'd1);
        @(negedge clk);
        check_off("R8 idle after bad");
        trig0 = 2'b10;
        #1 check("R8 good again", {11'd0, cfg_bad}, 12'd0);
        settle0 = 8'd1;
        #1 check("R8 settle0", {11'd0, cfg_bad}, 12'd1);
        settle0 = '0;
        continuous_mode = 1'b0;
        #1 check("R8 not continuous", {11'd0, cfg_bad}, 12'd1);
        continuous_mode = 1'b1;
        trig1 = 2'b00;
        settle1 = 8'd3;
        #1 check("R8 ch1 ignored single-ended", {11'd0, cfg_bad}, 12'd0);
        diff_mode = 1'b1;
        #1 check("R8 ch1 checked in diff", {11'd0, cfg_bad}, 12'd1);
        diff_mode = 1'b0;
        trig1 = 2'b10;
        settle1 = '0;
        @(negedge clk);
        mj = 0;
        run_check("R1 R8 restart at entry 0", 8, 2);
    endtask

    task automatic t_enable();
        ch0_en = 1'b0;
        @(negedge clk);
        check_off("R1 ch0 disabled");
        ch0_en = 1'b1;
        @(negedge clk);
        mj = 0;
        run_check("R1 ch0 restart", 6, 2);
        reset_on_gate = 1'b0;
        run_check("R1 freeze mode run", 7, 2);
        sine_en = 1'b0;
        @(negedge clk);
        check_off("R1 sine disabled");
        sine_en = 1'b1;
        @(negedge clk);
        mj = 0;
        run_check("R1 re-enable at entry 0", 6, 2);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_wave();
        t_freeze();
        t_diff();
        t_cfg();
        t_enable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule